// File: doc/BRIEF.md
# Set/Clear Programmed Interrupt Controller

This block gathers up to 32 interrupt sources and presents them on two processor request lines and one wakeup line. Software programs it through a plain single-cycle register bus. Every control field has a write-one-to-set word and a write-one-to-clear word. Each source carries a 3-bit trigger code, a routing bit that picks one of the two request lines, an enable mask bit, a wakeup enable bit and a source-select bit. Two status words show, for each request line, which enabled sources are pending right now.

Edge-triggered sources are sampled through a two-flop synchroniser and held in per-source rising and falling flags until software clears them. Level-triggered sources are not held, so their request follows the synchronised input. A test word ORs forced pending bits into the status path so that software can check the routing without any source activity. To cover 64 sources, a system uses two instances: source numbers 0 to 31 go to one instance and 32 to 63 go to the other, with bit 5 of the source number choosing the instance.

The bus has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled high. Read data is combinational from `bus_addr`. Request and wakeup outputs are plain levels.

Top module: `ic_setclr_ctrl`

## Requirements
- R1: After reset every register is zero: trigger codes, routing, mask, wakeup enable, source select, edge flags and test word. `req0_o`, `req1_o` and `wake_o` are low.
- R2: Word addresses: plane k has its set word at 2k and its clear word at 2k+1, for k = 0 (trigger bit 0), 1 (trigger bit 1), 2 (trigger bit 2), 3 (routing), 4 (mask), 5 (wakeup), 6 (source select). The other words are 14 (mask read), 15 (rising flags), 16 (falling flags), 17 (status 0), 18 (status 1) and 19 (test). A set write ORs the data into the plane and a clear write removes the 1 bits, leaving all other bits unchanged. Reading either alias of a plane returns the plane's value.
- R3: The trigger code is {bit2, bit1, bit0}. 101 is active-high level and 110 is active-low level. 000, 100 and 111 disable the source.
- R4: Code 001 makes a source pending on a latched rising edge, 010 on a latched falling edge, and 011 on either. The input is sampled through two flops. A latched edge stays pending after the input returns to its old level.
- R5: Writing 1 bits to word 15 clears those rising flags, and writing them to word 16 clears those falling flags. Flags at other bit positions and of the other direction are unchanged.
- R6: Routing bit 1 sends a pending, enabled source to `req0_o` and status 0. Routing bit 0 sends it to `req1_o` and status 1.
- R7: A source reaches either request line or status word only while its mask bit is 1.
- R8: `wake_o` is high when any source is pending with its wakeup enable set, whatever its mask bit.
- R9: A source whose source-select bit is 0 is never pending, whatever its input or trigger code.
- R10: Each 1 bit in the test word (word 19, written directly) makes that source pending, regardless of its input, trigger code and source select.
- R11: A level source is not latched, so its request drops once the deasserted input has passed the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Raw source inputs, asynchronous to clk |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wakeup request |

## Verification
The main decode is driven with a table. Each entry gives a source, a trigger code, a routing bit and an input transition before-to-after. Pairs of entries apply opposite transitions to the same code, which separates rising from falling, live level from latched edge, and high level from low level. The three disabled codes are given an edge that would otherwise fire. Routing is flipped on the same source so that a swapped request line shows up. Directed cases then check partial set/clear masks, which flags a directed edge clear removes, the mask against wakeup, source select and the test word.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int NPLANE   = 7;
  localparam int PL_CFG0  = 0;
  localparam int PL_CFG1  = 1;
  localparam int PL_CFG2  = 2;
  localparam int PL_ROUTE = 3;
  localparam int PL_MASK  = 4;
  localparam int PL_WAKE  = 5;
  localparam int PL_SEL   = 6;

  localparam int ADR_MASK_RD = 2 * NPLANE;
  localparam int ADR_RISE    = ADR_MASK_RD + 1;
  localparam int ADR_FALL    = ADR_MASK_RD + 2;
  localparam int ADR_STAT0   = ADR_MASK_RD + 3;
  localparam int ADR_STAT1   = ADR_MASK_RD + 4;
  localparam int ADR_TEST    = ADR_MASK_RD + 5;

  typedef enum logic [2:0] {
    TRG_OFF0  = 3'b000,
    TRG_RISE  = 3'b001,
    TRG_FALL  = 3'b010,
    TRG_BOTH  = 3'b011,
    TRG_OFF1  = 3'b100,
    TRG_HIGH  = 3'b101,
    TRG_LOW   = 3'b110,
    TRG_OFF2  = 3'b111
  } trig_e;

  function automatic logic trig_eval(logic [2:0] code, logic lvl,
                                     logic rf, logic ff);
    case (trig_e'(code))
      TRG_RISE: return rf;
      TRG_FALL: return ff;
      TRG_BOTH: return rf | ff;
      TRG_HIGH: return lvl;
      TRG_LOW:  return ~lvl;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ic_sync_edge.sv
module ic_sync_edge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] rise_clr,
  input  logic [N-1:0] fall_clr,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise_flag,
  output logic [N-1:0] fall_flag
);
  logic [N-1:0] meta_q, sync_q, prev_q;
  logic [N-1:0] rise_det, fall_det;

  assign rise_det = sync_q & ~prev_q;
  assign fall_det = ~sync_q & prev_q;
  assign lvl      = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_q    <= '0;
      prev_q    <= '0;
      rise_flag <= '0;
      fall_flag <= '0;
    end else begin
      meta_q    <= raw;
      sync_q    <= meta_q;
      prev_q    <= sync_q;
      rise_flag <= (rise_flag & ~rise_clr) | rise_det;
      fall_flag <= (fall_flag & ~fall_clr) | fall_det;
    end
  end

  // R5
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_clr) |=> ((rise_flag & $past(rise_clr & ~rise_det)) == '0));
  // R5
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_clr) |=> ((fall_flag & $past(fall_clr & ~fall_det)) == '0));
  // R4
  rise_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_det == '0) |=> ((rise_flag & ~$past(rise_flag)) == '0));
endmodule

// File: rtl/ic_regfile.sv
module ic_regfile
  import ic_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [N-1:0]               wdata,
  output logic [NPLANE-1:0][N-1:0]   plane_q,
  output logic [N-1:0]               test_q,
  output logic [N-1:0]               rise_clr,
  output logic [N-1:0]               fall_clr
);
  for (genvar k = 0; k < NPLANE; k++) begin : g_plane
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(2 * k + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        plane_q[k] <= '0;
      else if (wr && addr == SET_A)
        plane_q[k] <= plane_q[k] | wdata;
      else if (wr && addr == CLR_A)
        plane_q[k] <= plane_q[k] & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      test_q <= '0;
    else if (wr && addr == ADDR_W'(ADR_TEST))
      test_q <= wdata;
  end

  assign rise_clr = (wr && addr == ADDR_W'(ADR_RISE)) ? wdata : '0;
  assign fall_clr = (wr && addr == ADDR_W'(ADR_FALL)) ? wdata : '0;

  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(2 * PL_MASK)) |=>
      (plane_q[PL_MASK] == ($past(plane_q[PL_MASK]) | $past(wdata))));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(2 * PL_MASK + 1)) |=>
      (plane_q[PL_MASK] == ($past(plane_q[PL_MASK]) & ~$past(wdata))));
endmodule

// File: rtl/ic_core.sv
module ic_core
  import ic_pkg::*;
#(
  parameter int N = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPLANE-1:0][N-1:0] plane_q,
  input  logic [N-1:0]             test_q,
  input  logic [N-1:0]             lvl,
  input  logic [N-1:0]             rise_flag,
  input  logic [N-1:0]             fall_flag,
  output logic [N-1:0]             stat0,
  output logic [N-1:0]             stat1,
  output logic                     req0,
  output logic                     req1,
  output logic                     wake
);
  logic [N-1:0] pend;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    assign code = {plane_q[PL_CFG2][i], plane_q[PL_CFG1][i], plane_q[PL_CFG0][i]};
    assign pend[i] = test_q[i] |
                     (plane_q[PL_SEL][i] &
                      trig_eval(code, lvl[i], rise_flag[i], fall_flag[i]));
  end

  assign stat0 = pend & plane_q[PL_MASK] & plane_q[PL_ROUTE];
  assign stat1 = pend & plane_q[PL_MASK] & ~plane_q[PL_ROUTE];
  assign req0  = |stat0;
  assign req1  = |stat1;
  assign wake  = |(pend & plane_q[PL_WAKE]);

  // R7
  req0_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req0 |-> (|(plane_q[PL_MASK] & plane_q[PL_ROUTE])));
  // R6
  stat_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0 & stat1) == '0));
  // R8
  wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|plane_q[PL_WAKE]));
endmodule

// File: rtl/ic_setclr_ctrl.sv
module ic_setclr_ctrl
  import ic_pkg::*;
#(
  parameter int N      = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [NPLANE-1:0][N-1:0] plane_q;
  logic [N-1:0] test_q, rise_clr, fall_clr;
  logic [N-1:0] lvl, rise_flag, fall_flag, stat0, stat1;

  ic_regfile #(.N(N), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .plane_q(plane_q), .test_q(test_q), .rise_clr(rise_clr), .fall_clr(fall_clr)
  );

  ic_sync_edge #(.N(N)) edge_i (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .rise_clr(rise_clr),
    .fall_clr(fall_clr), .lvl(lvl), .rise_flag(rise_flag), .fall_flag(fall_flag)
  );

  ic_core #(.N(N)) core_i (
    .clk(clk), .rst_n(rst_n), .plane_q(plane_q), .test_q(test_q), .lvl(lvl),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .stat0(stat0), .stat1(stat1),
    .req0(req0_o), .req1(req1_o), .wake(wake_o)
  );

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < NPLANE; k++)
      if (int'(bus_addr) >> 1 == k) bus_rdata = plane_q[k];
    case (int'(bus_addr))
      ADR_MASK_RD: bus_rdata = plane_q[PL_MASK];
      ADR_RISE:    bus_rdata = rise_flag;
      ADR_FALL:    bus_rdata = fall_flag;
      ADR_STAT0:   bus_rdata = stat0;
      ADR_STAT1:   bus_rdata = stat1;
      ADR_TEST:    bus_rdata = test_q;
      default:     ;
    endcase
  end
endmodule

// File: tb/ic_setclr_ctrl_tb.sv
module ic_setclr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req0_o, req1_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  ic_setclr_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
  );

  // {src, code, route, before, after, exp_req0, exp_req1}
  localparam logic [12:0] VEC [14] = '{
    {5'd3,  3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 high level, R6 route 0
    {5'd3,  3'b101, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R6 route 1
    {5'd7,  3'b110, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 low level
    {5'd7,  3'b110, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 low level idle
    {5'd10, 3'b001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 rising
    {5'd10, 3'b001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R4 rising ignores fall
    {5'd12, 3'b010, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 falling
    {5'd12, 3'b010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 falling ignores rise
    {5'd20, 3'b011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 both, rise
    {5'd20, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R4 both, fall
    {5'd31, 3'b000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 off 000
    {5'd31, 3'b100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 off 100
    {5'd0,  3'b111, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 off 111
    {5'd0,  3'b101, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}   // R3 steady high
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int k = 0; k < 7; k++) wr(2 * k + 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] one;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 req0", {31'b0, req0_o}, 32'd0);
    check("R1 req1", {31'b0, req1_o}, 32'd0);
    check("R1 wake", {31'b0, wake_o}, 32'd0);
    rd(14, r); check("R1 mask", r, 32'd0);
    rd(6, r);  check("R1 route", r, 32'd0);
    rd(10, r); check("R1 wake enable", r, 32'd0);

    // R2 partial set/clear on routing plane
    wr(6, 32'hF0F0_00FF);
    wr(7, 32'h0000_000F);
    rd(6, r); check("R2 set alias read", r, 32'hF0F0_00F0);
    rd(7, r); check("R2 clear alias read", r, 32'hF0F0_00F0);
    wr(7, 32'hFFFF_FFFF);

    // Table walk: R3 R4 R6
    foreach (VEC[v]) begin
      logic [4:0] src;
      logic [2:0] code;
      src = VEC[v][12:8]; code = VEC[v][7:5];
      one = 32'd1 << src;
      clear_all();
      irq_in = '0; irq_in[src] = VEC[v][3];
      settle();
      wr(15, 32'hFFFF_FFFF); wr(16, 32'hFFFF_FFFF);
      for (int b = 0; b < 3; b++) if (code[b]) wr(2 * b, one);
      if (VEC[v][4]) wr(6, one);
      wr(8, one); wr(12, one);
      irq_in[src] = VEC[v][2];
      settle();
      check($sformatf("R3/R4/R6 vec %0d req0", v), {31'b0, req0_o}, {31'b0, VEC[v][1]});
      check($sformatf("R3/R4/R6 vec %0d req1", v), {31'b0, req1_o}, {31'b0, VEC[v][0]});
      rd(17, r);
      check($sformatf("R6 vec %0d status0", v), r, VEC[v][1] ? one : 32'd0);
      rd(18, r);
      check($sformatf("R6 vec %0d status1", v), r, VEC[v][0] ? one : 32'd0);
    end

    // R4 latch persists; R5 directed clears
    clear_all(); irq_in = '0; settle();
    wr(15, 32'hFFFF_FFFF); wr(16, 32'hFFFF_FFFF);
    one = 32'd1 << 5;
    wr(0, one); wr(6, one); wr(8, one); wr(12, one);
    irq_in[5] = 1'b1; settle();
    irq_in[5] = 1'b0; settle();
    check("R4 latched after return", {31'b0, req0_o}, 32'd1);
    wr(16, one);
    check("R5 fall clear keeps rise", {31'b0, req0_o}, 32'd1);
    wr(15, 32'hFFFF_FFDF);
    rd(15, r); check("R5 other bit clear keeps flag", r, one);
    wr(15, one);
    check("R5 rise clear", {31'b0, req0_o}, 32'd0);

    // R7 mask, R8 wake, R11 level drop
    clear_all(); irq_in = '0; settle();
    one = 32'd1 << 8;
    wr(0, one); wr(4, one); wr(6, one); wr(12, one);
    irq_in[8] = 1'b1; settle();
    check("R7 masked off", {31'b0, req0_o}, 32'd0);
    wr(8, one);
    check("R7 mask on", {31'b0, req0_o}, 32'd1);
    rd(14, r); check("R7 mask read", r, one);
    wr(9, one);
    check("R7 mask cleared", {31'b0, req0_o}, 32'd0);
    wr(10, one);
    check("R8 wake while masked", {31'b0, wake_o}, 32'd1);
    wr(8, one);
    irq_in[8] = 1'b0; settle();
    check("R11 level drop req", {31'b0, req0_o}, 32'd0);
    check("R11 level drop wake", {31'b0, wake_o}, 32'd0);

    // R9 source select off
    irq_in[8] = 1'b1; settle();
    wr(13, one);
    check("R9 unselected req", {31'b0, req0_o}, 32'd0);
    check("R9 unselected wake", {31'b0, wake_o}, 32'd0);
    rd(17, r); check("R9 unselected status0", r, 32'd0);

    // R10 test force
    clear_all(); irq_in = '0; settle();
    one = 32'd1 << 25;
    wr(8, one);
    wr(19, one);
    check("R10 forced req1", {31'b0, req1_o}, 32'd1);
    rd(18, r); check("R10 forced status1", r, one);
    wr(19, 32'd0);
    check("R10 force removed", {31'b0, req1_o}, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule